// File: doc/BRIEF.md
# Data-Memory Pointer Address Generator

This block turns a decoded load or store request into a data-memory address. It can take the address from one of three 16-bit pointer registers, or from a full 16-bit address carried in a second instruction word. When a pointer is used, the block can also hand an updated pointer value back to the register file. The pointer registers themselves sit outside the block: their current values arrive on a flat bus, and the block returns one write-back value together with a one-hot enable that names the pointer to update.

The block offers five addressing forms:
- plain indirect;
- indirect with increment after the access;
- indirect with decrement before the access;
- indirect plus an unsigned 6-bit offset;
- two-word direct.

The pointer at index `REDUCED_IDX` cannot use the offset form. A request for that combination is rejected. For the direct form, the block waits in a busy state until the second word is presented, and only then issues the memory strobe. All results are registered.

Top module: `dmem_agu`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `mem_stb`, `mem_we`, `mem_addr`, `wb_en`, `wb_val`, `illegal` and `busy` are all zero.
- R2: A request is accepted when `busy` is low. An accepted request with mode code 0 (plain indirect) gives, one cycle later, `mem_stb`=1 and `mem_addr` equal to the selected pointer, with `wb_en`=0.
- R3: Mode code 1 (increment after) addresses the unchanged pointer. One cycle later it returns `wb_val` = pointer+1, wrapping modulo 2^16 (0xFFFF gives 0x0000).
- R4: Mode code 2 (decrement before) uses pointer-1, modulo 2^16, both as `mem_addr` and as `wb_val` (0x0000 gives 0xFFFF).
- R5: Mode code 3 (offset) gives `mem_addr` = pointer + zero-extended `req_disp` (0 to 63), modulo 2^16. It raises no `wb_en`, so the pointer is left as it was.
- R6: Mode code 3 on the pointer at index `REDUCED_IDX` (default 0) raises `illegal` for one cycle. It produces no `mem_stb` and no `wb_en`.
- R7: Mode code 4 (direct) raises `busy` one cycle after the request and issues no strobe. `busy` stays high while `word2_valid` is low. The first cycle with `word2_valid` high gives, one cycle later, `mem_stb`=1, `mem_addr`=`word2_addr` and `busy`=0.
- R8: While `busy` is high, `req_valid` is ignored: no strobe, no `wb_en` and no `illegal` come from it.
- R9: `mem_we` copies `req_store` of the accepted request. For the direct form, the value captured at request time is used when the strobe is finally issued.
- R10: A pointer index of `NUM_PTR` or above, or a mode code from 5 to 7, raises `illegal` for one cycle with no strobe and no `wb_en`.
- R11: `wb_en` is one-hot on the selected pointer index (bit i for pointer i) and is set only for mode codes 1 and 2. It is asserted in the same cycle as the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load/store request present |
| req_ptr | input | PSEL_W | Pointer index |
| req_mode | input | 3 | Addressing form: 0 indirect, 1 increment after, 2 decrement before, 3 offset, 4 direct |
| req_disp | input | DISP_W | Unsigned offset for mode 3 |
| req_store | input | 1 | 1 = store, 0 = load |
| ptr_bus | input | NUM_PTR*ADDR_W | Current pointer values, pointer i in bits [i*ADDR_W +: ADDR_W] |
| word2_valid | input | 1 | Second instruction word present |
| word2_addr | input | ADDR_W | Direct address from the second word |
| mem_stb | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write enable accompanying the strobe |
| mem_addr | output | ADDR_W | Effective address |
| wb_en | output | NUM_PTR | One-hot pointer write-back enable |
| wb_val | output | ADDR_W | Pointer write-back value |
| illegal | output | 1 | Rejected request pulse |
| busy | output | 1 | Waiting for the second word |

## Verification
Every pointer-based result appears on the outputs after exactly one clock edge, counted from the edge that samples the request. This covers the strobe, address, write-back and illegal pulse. For the direct form, `busy` rises one edge after the request. The strobe comes one edge after the first edge that samples `word2_valid` high. The bench drives inputs on the falling edge, lets one rising edge pass, and samples at the next falling edge. For the direct form it also samples each waiting cycle to confirm that nothing is issued early.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    AM_IND     = 3'd0,
    AM_POSTINC = 3'd1,
    AM_PREDEC  = 3'd2,
    AM_DISP    = 3'd3,
    AM_DIRECT  = 3'd4
  } agu_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } agu_state_e;
endpackage

// File: rtl/agu_ptr_sel.sv
module agu_ptr_sel #(
  parameter int ADDR_W      = 16,
  parameter int NUM_PTR     = 3,
  parameter int PSEL_W      = 2,
  parameter int REDUCED_IDX = 0
) (
  input  logic [NUM_PTR*ADDR_W-1:0] ptr_bus,
  input  logic [PSEL_W-1:0]         sel,
  output logic [ADDR_W-1:0]         sel_val,
  output logic                      sel_exists,
  output logic                      sel_has_disp,
  output logic [NUM_PTR-1:0]        sel_onehot
);
  logic [ADDR_W-1:0]  slot [NUM_PTR];
  logic [NUM_PTR-1:0] hit;
  logic [NUM_PTR-1:0] disp_cap;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_slot
    assign slot[g]     = ptr_bus[g*ADDR_W +: ADDR_W];
    assign hit[g]      = (sel == PSEL_W'(g));
    assign disp_cap[g] = (g != REDUCED_IDX);
  end

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (hit[i]) sel_val = slot[i];
    end
  end

  assign sel_exists   = |hit;
  assign sel_has_disp = |(hit & disp_cap);
  assign sel_onehot   = hit;
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  agu_mode_e         mode,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] new_ptr,
  output logic              updates
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam int PAD_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] inc_v;
  logic [ADDR_W-1:0] dec_v;
  logic [ADDR_W-1:0] off_v;

  assign inc_v = base + ONE;
  assign dec_v = base - ONE;
  assign off_v = base + {{PAD_W{1'b0}}, disp};

  always_comb begin
    ea      = base;
    new_ptr = base;
    updates = 1'b0;
    case (mode)
      AM_POSTINC: begin
        new_ptr = inc_v;
        updates = 1'b1;
      end
      AM_PREDEC: begin
        ea      = dec_v;
        new_ptr = dec_v;
        updates = 1'b1;
      end
      AM_DISP:  ea = off_v;
      default:  ea = base;
    endcase
  end
endmodule

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              sel_exists,
  input  logic              sel_has_disp,
  input  logic              word2_valid,
  output logic              fire_ptr,
  output logic              start_direct,
  output logic              fire_direct,
  output logic              flag_bad,
  output logic              busy_next
);
  agu_state_e state_q;
  agu_state_e state_d;
  logic idle;
  logic ptr_mode;

  assign idle     = (state_q == ST_IDLE);
  assign ptr_mode = (req_mode <= MODE_W'(AM_DISP));

  always_comb begin
    fire_ptr     = 1'b0;
    start_direct = 1'b0;
    flag_bad     = 1'b0;
    fire_direct  = 1'b0;
    state_d      = state_q;
    if (idle) begin
      if (req_valid) begin
        if (req_mode == MODE_W'(AM_DIRECT)) begin
          start_direct = 1'b1;
          state_d      = ST_WAIT;
        end else if (ptr_mode && sel_exists &&
                     (req_mode != MODE_W'(AM_DISP) || sel_has_disp)) begin
          fire_ptr = 1'b1;
        end else begin
          flag_bad = 1'b1;
        end
      end
    end else if (word2_valid) begin
      fire_direct = 1'b1;
      state_d     = ST_IDLE;
    end
  end

  assign busy_next = (state_d == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/dmem_agu.sv
module dmem_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NUM_PTR     = 3,
  parameter int DISP_W      = 6,
  parameter int REDUCED_IDX = 0,
  parameter int PSEL_W      = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [PSEL_W-1:0]         req_ptr,
  input  logic [MODE_W-1:0]         req_mode,
  input  logic [DISP_W-1:0]         req_disp,
  input  logic                      req_store,
  input  logic [NUM_PTR*ADDR_W-1:0] ptr_bus,
  input  logic                      word2_valid,
  input  logic [ADDR_W-1:0]         word2_addr,
  output logic                      mem_stb,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [NUM_PTR-1:0]        wb_en,
  output logic [ADDR_W-1:0]         wb_val,
  output logic                      illegal,
  output logic                      busy
);
  logic [ADDR_W-1:0]  sel_val;
  logic               sel_exists;
  logic               sel_has_disp;
  logic [NUM_PTR-1:0] sel_onehot;
  logic [ADDR_W-1:0]  ea;
  logic [ADDR_W-1:0]  new_ptr;
  logic               updates;
  logic               fire_ptr;
  logic               start_direct;
  logic               fire_direct;
  logic               flag_bad;
  logic               busy_next;
  logic               store_q;

  agu_ptr_sel #(
    .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .PSEL_W(PSEL_W), .REDUCED_IDX(REDUCED_IDX)
  ) u_sel (
    .ptr_bus(ptr_bus), .sel(req_ptr), .sel_val(sel_val),
    .sel_exists(sel_exists), .sel_has_disp(sel_has_disp), .sel_onehot(sel_onehot)
  );

  agu_addr_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_calc (
    .base(sel_val), .mode(agu_mode_e'(req_mode)), .disp(req_disp),
    .ea(ea), .new_ptr(new_ptr), .updates(updates)
  );

  agu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .sel_exists(sel_exists), .sel_has_disp(sel_has_disp), .word2_valid(word2_valid),
    .fire_ptr(fire_ptr), .start_direct(start_direct), .fire_direct(fire_direct),
    .flag_bad(flag_bad), .busy_next(busy_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_stb  <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      wb_en    <= '0;
      wb_val   <= '0;
      illegal  <= 1'b0;
      busy     <= 1'b0;
      store_q  <= 1'b0;
    end else begin
      mem_stb <= fire_ptr | fire_direct;
      illegal <= flag_bad;
      busy    <= busy_next;
      if (start_direct) store_q <= req_store;
      if (fire_ptr) begin
        mem_we   <= req_store;
        mem_addr <= ea;
      end else if (fire_direct) begin
        mem_we   <= store_q;
        mem_addr <= word2_addr;
      end else begin
        mem_we   <= 1'b0;
      end
      if (fire_ptr && updates) begin
        wb_en  <= sel_onehot;
        wb_val <= new_ptr;
      end else begin
        wb_en  <= '0;
      end
    end
  end
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int ADDR_W      = 16,
  parameter int NUM_PTR     = 3,
  parameter int DISP_W      = 6,
  parameter int REDUCED_IDX = 0,
  parameter int PSEL_W      = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_valid,
  input logic [PSEL_W-1:0]         req_ptr,
  input logic [2:0]                req_mode,
  input logic [NUM_PTR*ADDR_W-1:0] ptr_bus,
  input logic                      word2_valid,
  input logic [ADDR_W-1:0]         word2_addr,
  input logic                      mem_stb,
  input logic [ADDR_W-1:0]         mem_addr,
  input logic [NUM_PTR-1:0]        wb_en,
  input logic [ADDR_W-1:0]         wb_val,
  input logic                      illegal,
  input logic                      busy
);
  logic [ADDR_W-1:0] cur_ptr;
  logic              ptr_ok;

  always_comb begin
    cur_ptr = '0;
    ptr_ok  = 1'b0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (req_ptr == PSEL_W'(i)) begin
        cur_ptr = ptr_bus[i*ADDR_W +: ADDR_W];
        ptr_ok  = 1'b1;
      end
    end
  end

  AST_WB_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(wb_en)); // R11
  AST_WB_WITH_STB: assert property (@(posedge clk) disable iff (rst) (|wb_en) |-> mem_stb); // R11
  AST_STB_NOT_ILLEGAL: assert property (@(posedge clk) disable iff (rst) !(mem_stb && illegal)); // R6
  AST_POSTINC_ADDR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_mode == 3'd1 && ptr_ok) |=>
      (mem_stb && mem_addr == $past(cur_ptr) && wb_val == $past(cur_ptr) + ADDR_W'(1))); // R3
  AST_REDUCED_DISP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_mode == 3'd3 && req_ptr == PSEL_W'(REDUCED_IDX)) |=>
      (illegal && !mem_stb && wb_en == '0)); // R6
  AST_DIRECT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_mode == 3'd4) |=> (busy && !mem_stb)); // R7
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !word2_valid) |=> (busy && !mem_stb && !illegal && wb_en == '0)); // R8
  AST_DIRECT_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (busy && word2_valid) |=> (mem_stb && !busy && mem_addr == $past(word2_addr))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !busy) |=> (!mem_stb && !illegal && wb_en == '0)); // R2
endmodule

bind dmem_agu agu_checker #(
  .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .DISP_W(DISP_W),
  .REDUCED_IDX(REDUCED_IDX), .PSEL_W(PSEL_W)
) u_agu_checker (.*);

// File: tb/test_dmem_agu.sv
module test_dmem_agu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_ptr = '0;
  logic [2:0]  req_mode = '0;
  logic [5:0]  req_disp = '0;
  logic        req_store = 1'b0;
  logic [15:0] p0 = '0, p1 = '0, p2 = '0;
  logic [47:0] ptr_bus;
  logic        word2_valid = 1'b0;
  logic [15:0] word2_addr = '0;
  logic        mem_stb, mem_we, illegal, busy;
  logic [15:0] mem_addr, wb_val;
  logic [2:0]  wb_en;
  int tests = 0;
  int fails = 0;

  assign ptr_bus = {p2, p1, p0};
  always #4 clk = ~clk;

  dmem_agu i_dmem_agu (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ptr(req_ptr),
    .req_mode(req_mode), .req_disp(req_disp), .req_store(req_store),
    .ptr_bus(ptr_bus), .word2_valid(word2_valid), .word2_addr(word2_addr),
    .mem_stb(mem_stb), .mem_we(mem_we), .mem_addr(mem_addr), .wb_en(wb_en),
    .wb_val(wb_val), .illegal(illegal), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] p, input logic [2:0] m,
                       input logic [5:0] d, input logic st);
    req_ptr = p; req_mode = m; req_disp = d; req_store = st; req_valid = 1'b1;
    step();
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 stb", mem_stb, 0);
    chk("R1 addr", mem_addr, 0);
    chk("R1 wb_en", wb_en, 0);
    chk("R1 busy/illegal/we", {busy, illegal, mem_we}, 0);
    rst = 1'b0;
    step();
    chk("R1 idle after reset", {mem_stb, busy, illegal, wb_en}, 0);
  endtask

  task automatic t_plain();
    p1 = 16'h1234;
    issue(2'd1, 3'd0, 6'd0, 1'b0);
    chk("R2 stb", mem_stb, 1);
    chk("R2 addr", mem_addr, 16'h1234);
    chk("R2 no wb", wb_en, 0);
    step();
    chk("R2 single strobe", mem_stb, 0);
  endtask

  task automatic t_postinc();
    p2 = 16'h00FF;
    issue(2'd2, 3'd1, 6'd0, 1'b0);
    chk("R3 addr", mem_addr, 16'h00FF);
    chk("R3 wb_val", wb_val, 16'h0100);
    chk("R11 wb_en p2", wb_en, 3'b100);
    p0 = 16'hFFFF;
    issue(2'd0, 3'd1, 6'd0, 1'b0);
    chk("R3 wrap addr", mem_addr, 16'hFFFF);
    chk("R3 wrap wb_val", wb_val, 16'h0000);
    chk("R11 wb_en p0", wb_en, 3'b001);
  endtask

  task automatic t_predec();
    p1 = 16'h0000;
    issue(2'd1, 3'd2, 6'd0, 1'b1);
    chk("R4 wrap addr", mem_addr, 16'hFFFF);
    chk("R4 wrap wb_val", wb_val, 16'hFFFF);
    chk("R11 wb_en p1", wb_en, 3'b010);
    p2 = 16'h8000;
    issue(2'd2, 3'd2, 6'd0, 1'b0);
    chk("R4 addr", mem_addr, 16'h7FFF);
  endtask

  task automatic t_disp();
    p1 = 16'h0200;
    issue(2'd1, 3'd3, 6'd0, 1'b0);
    chk("R5 disp 0", mem_addr, 16'h0200);
    chk("R5 no wb", wb_en, 0);
    p2 = 16'hFFF0;
    issue(2'd2, 3'd3, 6'd63, 1'b0);
    chk("R5 disp 63 wrap", mem_addr, 16'h002F);
    chk("R5 stb", mem_stb, 1);
    issue(2'd1, 3'd3, 6'd63, 1'b0);
    chk("R5 disp 63", mem_addr, 16'h023F);
  endtask

  task automatic t_reduced();
    p0 = 16'h4000;
    issue(2'd0, 3'd3, 6'd5, 1'b1);
    chk("R6 illegal", illegal, 1);
    chk("R6 no stb", mem_stb, 0);
    chk("R6 no wb", wb_en, 0);
    step();
    chk("R6 pulse ends", illegal, 0);
  endtask

  task automatic t_bad_codes();
    issue(2'd3, 3'd0, 6'd0, 1'b0);
    chk("R10 bad ptr", {illegal, mem_stb}, 2'b10);
    issue(2'd1, 3'd6, 6'd0, 1'b0);
    chk("R10 bad mode", {illegal, mem_stb, wb_en}, 5'b10000);
  endtask

  task automatic t_direct();
    issue(2'd0, 3'd4, 6'd0, 1'b1);
    chk("R7 busy", busy, 1);
    chk("R7 no early stb", mem_stb, 0);
    p1 = 16'h0010;
    issue(2'd1, 3'd1, 6'd0, 1'b0);
    chk("R8 ignored stb", mem_stb, 0);
    chk("R8 ignored wb/illegal", {wb_en, illegal}, 0);
    chk("R7 still busy", busy, 1);
    word2_addr = 16'hBEEF;
    word2_valid = 1'b1;
    step();
    word2_valid = 1'b0;
    chk("R7 stb", mem_stb, 1);
    chk("R7 addr", mem_addr, 16'hBEEF);
    chk("R9 direct we", mem_we, 1);
    chk("R7 busy clear", busy, 0);
    step();
    chk("R7 single strobe", mem_stb, 0);
  endtask

  task automatic t_store();
    p2 = 16'h0042;
    issue(2'd2, 3'd0, 6'd0, 1'b1);
    chk("R9 store we", mem_we, 1);
    issue(2'd2, 3'd0, 6'd0, 1'b0);
    chk("R9 load we", mem_we, 0);
    issue(2'd0, 3'd4, 6'd0, 1'b0);
    req_store = 1'b1;
    word2_addr = 16'h0101;
    word2_valid = 1'b1;
    step();
    word2_valid = 1'b0;
    chk("R9 direct load we", {mem_stb, mem_we}, 2'b10);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    t_plain();
    t_postinc();
    t_predec();
    t_disp();
    t_reduced();
    t_bad_codes();
    t_direct();
    t_store();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule